// File: doc/BRIEF.md
# Signed/Unsigned Byte Dot-Product Row Accumulator

This block updates one output row of an integer matrix product, C[m][n] += sum over k of A[m][k]*B[k][n]. Every operand dword carries four 8-bit elements, and every accumulator lane is a 32-bit signed integer. A start strobe captures the signedness mode, the inner length K (in dwords) and the active column count N, and it loads the starting accumulator row from `c_in`. From the next cycle the block takes one A dword and one B row per cycle for K cycles, updating all active columns at once. After the last dword it raises `done` for one cycle, and the finished row is on `c_out`.

Each A dword is combined with the matching B dword of every column as a four-byte dot product. The exact sum is added to the lane, and the result is clamped to the signed 32-bit range, so the accumulator never wraps.

Top module: `int8_dotacc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `c_out` is all zeros.
- R2: A `start` while idle loads `c_in` into the accumulator row and captures `mode`, `k_in` and `n_in`.
- R3: After each dword update, a lane result above 0x7FFFFFFF becomes 0x7FFFFFFF and a result below -2^31 becomes 0x80000000. The clamp is applied after every dword, not only at the end of the row.
- R4: Lanes with index at or above the captured N keep their loaded `c_in` value for the whole operation.
- R5: For lane n, the dword update adds the sum over j=0..3 of A byte j times B byte j. A byte j is `a_dw[8j+7:8j]`. B byte j of lane n is `b_row[32n+8j+7:32n+8j]`. The four products are summed exactly.
- R6: `mode` is encoded as 0 = A signed, B signed; 1 = A signed, B unsigned; 2 = A unsigned, B signed; 3 = A unsigned, B unsigned.
- R7: With K > 0, dwords are taken on the K clock edges that follow the start edge. `busy` is 1 in those cycles. `done` is 1 for exactly one cycle after the last dword edge, and `busy` is 0 at that time.
- R8: While `busy` is 1, `start`, `mode`, `k_in`, `n_in` and `c_in` have no effect on the result.
- R9: With K = 0, `done` rises one cycle after start and `c_out` equals `c_in`. A `k_in` or `n_in` above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a row operation (ignored while busy) |
| mode | input | 2 | Signedness of the A and B bytes |
| k_in | input | 5 | Inner length in dwords |
| n_in | input | 5 | Active column count |
| c_in | input | 512 | Initial accumulator row, lane n at bits 32n+31:32n |
| a_dw | input | 32 | A dword for the current k |
| b_row | input | 512 | B row k, one dword per column |
| busy | output | 1 | Consuming dwords |
| done | output | 1 | One-cycle completion pulse |
| c_out | output | 512 | Accumulator row |

## Verification
A wrong sign extension in a single mode shows up as a bad lane on `c_out` at the first `done` of that mode. For this reason every mode is run on data that contains bytes with the top bit set. A clamp that is applied only at the end of the row, or that wraps instead, changes a lane value on the very next `done`. A dedicated two-dword case first saturates a lane and then pulls it back. A corrupted captured configuration shows up either as wrong untouched lanes or as `done` arriving on the wrong cycle, and the bench checks both at every completion.

// File: rtl/int8_dotacc.sv
module int8_dotacc #(
  parameter int LANES = 16,
  parameter int MAX_K = 16,
  localparam int CW = $clog2((LANES > MAX_K ? LANES : MAX_K) + 1),
  localparam int RW = LANES * 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] k_in,
  input  logic [CW-1:0] n_in,
  input  logic [RW-1:0] c_in,
  input  logic [31:0]   a_dw,
  input  logic [RW-1:0] b_row,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] c_out
);
  localparam logic signed [33:0] SAT_HI = 34'sd2147483647;
  localparam logic signed [33:0] SAT_LO = -34'sd2147483648;

  logic [1:0]    mode_q;
  logic [CW-1:0] k_q, n_q, cnt;
  logic [RW-1:0] acc;
  logic [31:0]   upd [LANES];

  wire           accept = start & ~busy;
  wire [CW-1:0]  k_eff  = (k_in > CW'(MAX_K)) ? CW'(MAX_K) : k_in;
  wire [CW-1:0]  n_eff  = (n_in > CW'(LANES)) ? CW'(LANES) : n_in;
  wire           a_sgn  = ~mode_q[1];
  wire           b_sgn  = ~mode_q[0];
  wire           last   = (cnt == k_q - CW'(1));

  assign c_out = acc;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [19:0] dot;
    logic signed [33:0] sum;
    always_comb begin
      dot = '0;
      for (int j = 0; j < 4; j++) begin
        logic signed [19:0] ae, be;
        ae  = {{12{a_sgn & a_dw[8*j+7]}}, a_dw[8*j +: 8]};
        be  = {{12{b_sgn & b_row[32*i+8*j+7]}}, b_row[32*i+8*j +: 8]};
        dot = dot + ae * be;
      end
      sum = $signed({{2{acc[32*i+31]}}, acc[32*i +: 32]}) + $signed({{14{dot[19]}}, dot});
    end
    assign upd[i] = (sum > SAT_HI) ? 32'h7FFF_FFFF :
                    (sum < SAT_LO) ? 32'h8000_0000 : sum[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mode_q <= '0;
      k_q    <= '0;
      n_q    <= '0;
      cnt    <= '0;
      acc    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mode_q <= mode;
        k_q    <= k_eff;
        n_q    <= n_eff;
        cnt    <= '0;
        acc    <= c_in;
        busy   <= (k_eff != '0);
        done   <= (k_eff == '0);
      end else if (busy) begin
        for (int i = 0; i < LANES; i++)
          if (CW'(i) < n_q) acc[32*i +: 32] <= upd[i];
        cnt <= cnt + CW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/int8_dotacc_chk.sv
module int8_dotacc_chk #(
  parameter int LANES = 16,
  parameter int CW = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic [1:0]          mode_q,
  input logic [CW-1:0]       k_q,
  input logic [CW-1:0]       n_q,
  input logic [CW-1:0]       cnt,
  input logic [LANES*32-1:0] acc
);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < k_q));

  a_r8_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mode_q) && $stable(k_q) && $stable(n_q)));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    a_r4_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (CW'(i) >= n_q)) |=> $stable(acc[32*i +: 32]));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !acc[32*i+31] && (acc[32*i+18 +: 13] == '1)) |=> !acc[32*i+31]);

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && acc[32*i+31] && (acc[32*i+18 +: 13] == '0)) |=> acc[32*i+31]);
  end
endmodule

bind int8_dotacc int8_dotacc_chk #(.LANES(LANES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_q(mode_q),
  .k_q(k_q), .n_q(n_q), .cnt(cnt), .acc(acc)
);

// File: tb/int8_dotacc_tb.sv
module int8_dotacc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int RW = LANES * 32;
  localparam int NV = 8;
  // {mode, k, n, seed}
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 5'd4,  5'd16, 32'h1234_5678},
    {2'd1, 5'd16, 5'd16, 32'hCAFE_0001},
    {2'd2, 5'd7,  5'd9,  32'h0BAD_F00D},
    {2'd3, 5'd16, 5'd16, 32'h5EED_0003},
    {2'd0, 5'd1,  5'd1,  32'h0000_0042},
    {2'd3, 5'd20, 5'd25, 32'h7777_1111},
    {2'd1, 5'd3,  5'd0,  32'h9999_2222},
    {2'd2, 5'd0,  5'd16, 32'hABCD_EF01}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode_i = 0;
  logic [4:0] k_i = 0, n_i = 0;
  logic [RW-1:0] c_i = '0, b_i = '0;
  logic [31:0] a_i = '0;
  logic busy, done;
  logic [RW-1:0] c_out;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0]   a_mem [16];
  logic [RW-1:0] b_mem [16];
  logic [RW-1:0] cin_v, exp_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  int8_dotacc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_i), .k_in(k_i), .n_in(n_i),
    .c_in(c_i), .a_dw(a_i), .b_row(b_i), .busy(busy), .done(done), .c_out(c_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lcg(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic gen(input logic [31:0] seed);
    logic [31:0] x = seed;
    for (int k = 0; k < 16; k++) begin
      x = lcg(x); a_mem[k] = x;
      for (int n = 0; n < LANES; n++) begin x = lcg(x); b_mem[k][32*n +: 32] = x; end
    end
    for (int n = 0; n < LANES; n++) begin x = lcg(x); cin_v[32*n +: 32] = x; end
  endtask

  // R5, R6, R3: behavioural model
  task automatic ref_row(input logic [1:0] mode, input int keff, input int neff);
    exp_v = cin_v;
    for (int n = 0; n < neff; n++) begin
      longint acc = longint'($signed(cin_v[32*n +: 32]));
      for (int kk = 0; kk < keff; kk++) begin
        longint s = 0;
        for (int j = 0; j < 4; j++) begin
          logic [7:0] ab = a_mem[kk][8*j +: 8];
          logic [7:0] bb = b_mem[kk][32*n + 8*j +: 8];
          longint av = mode[1] ? longint'(ab) : longint'($signed(ab));
          longint bv = mode[0] ? longint'(bb) : longint'($signed(bb));
          s += av * bv;
        end
        acc += s;
        if (acc > 64'sd2147483647) acc = 64'sd2147483647;
        if (acc < -64'sd2147483648) acc = -64'sd2147483648;
      end
      exp_v[32*n +: 32] = acc[31:0];
    end
  endtask

  task automatic run(input logic [1:0] mode, input int kraw, input int nraw, input bit poke, input string tag);
    int keff = (kraw > 16) ? 16 : kraw;
    int neff = (nraw > 16) ? 16 : nraw;
    ref_row(mode, keff, neff);
    @(negedge clk);
    start = 1; mode_i = mode; k_i = 5'(kraw); n_i = 5'(nraw); c_i = cin_v;
    for (int kk = 0; kk < keff; kk++) begin
      @(negedge clk);
      if (kk == 0) chk(busy === 1'b1 && done === 1'b0, {tag, " R7 busy"}, RW'(busy), RW'(1));
      start = poke && (kk == 1);
      mode_i = start ? ~mode : mode; c_i = start ? ~cin_v : cin_v; k_i = start ? 5'd0 : k_i;
      a_i = a_mem[kk]; b_i = b_mem[kk];
    end
    @(negedge clk);
    start = 0;
    chk(done === 1'b1 && busy === 1'b0, {tag, " R7 done"}, RW'(done), RW'(1));
    chk(c_out === exp_v, {tag, " R5 row"}, c_out, exp_v);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R7 pulse"}, RW'(done), RW'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && c_out === '0, "R1 reset", c_out, '0);
    rst_n = 1;
    for (int v = 0; v < NV; v++) begin
      gen(VEC[v][31:0]);
      run(VEC[v][43:42], int'(VEC[v][41:37]), int'(VEC[v][36:32]), v == 1,
          $sformatf("R2 R6 R4 R9 R8 vec%0d", v));
    end
    // R3: positive clamp
    for (int n = 0; n < LANES; n++) cin_v[32*n +: 32] = 32'h7FFF_FFF0;
    a_mem[0] = 32'hFFFF_FFFF; b_mem[0] = {LANES{32'hFFFF_FFFF}};
    run(2'd3, 1, 16, 0, "R3 sat hi");
    chk(c_out[31:0] === 32'h7FFF_FFFF, "R3 hi lane0", RW'(c_out[31:0]), RW'(32'h7FFF_FFFF));
    // R3: negative clamp
    for (int n = 0; n < LANES; n++) cin_v[32*n +: 32] = 32'h8000_0010;
    a_mem[0] = 32'h8080_8080;
    run(2'd1, 1, 16, 0, "R3 sat lo");
    chk(c_out[31:0] === 32'h8000_0000, "R3 lo lane0", RW'(c_out[31:0]), RW'(32'h8000_0000));
    // R3: clamp per dword, then pull back
    for (int n = 0; n < LANES; n++) cin_v[32*n +: 32] = 32'h7FFF_FFF0;
    a_mem[0] = 32'h7F7F_7F7F; b_mem[0] = {LANES{32'h7F7F_7F7F}};
    a_mem[1] = 32'h7F7F_7F7F; b_mem[1] = {LANES{32'h8181_8181}};
    run(2'd0, 2, 16, 0, "R3 per dword");
    chk(c_out[31:0] === 32'h7FFF_03FB, "R3 per dword lane0", RW'(c_out[31:0]), RW'(32'h7FFF_03FB));
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule